// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a signed-direction position count. Both phases and the index input are first brought into the local clock domain through two-flop synchronisers. The block then looks at every edge of either phase (four counts per full quadrature cycle) and infers direction from which phase leads. The count is bounded by a programmable ceiling and wraps at both ends. A qualified index pulse can return the count to zero.

Software or a neighbouring controller reaches the block through a small word-addressed register port. The control word holds an enable, a phase swap, an index-reset mode and a two-bit index gate. Further registers hold the ceiling, a sticky interrupt status word and an interrupt mask. The configuration is frozen while counting is enabled. One interrupt line is the OR of all status flags that are not masked. Noise filtering happens upstream in a separate block.

Top module: `qenc_counter`

## Requirements
- R1: With swap off, phase order (A,B) = 00→10→11→01→00 adds one to the count per edge, and the reverse order subtracts one. A phase change that is stable before clock edge t shows on `count_o` after edge t+2.
- R2: Control bit 1 (swap) exchanges the A and B inputs before decoding, so the order that counted up now counts down.
- R3: An up step with the count at or above the ceiling loads 0 and sets status bit 2. A down step at count 0 loads the ceiling and sets status bit 1.
- R4: A sample in which both phases changed leaves the count unchanged and sets status bit 4.
- R5: `dir_up` is 1 after reset. Every valid step sets it to its own direction, and a step opposite to the held direction sets status bit 3.
- R6: With control bit 2 set, a rising index edge while the decoded {A,B} equals control bits 4:3 loads 0 into the count. It sets status bit 2 if `dir_up` was 1 before that edge, otherwise bit 1. It wins over a step in the same cycle. With control bit 2 clear, the index has no effect.
- R7: With control bit 0 (enable) clear, the count, the direction and all step-driven status bits hold.
- R8: While enabled, a write to the ceiling is ignored, and a control write changes only bit 0.
- R9: After WDOG_CYCLES consecutive enabled cycles with no valid step, status bit 0 is set once.
- R10: Writing 1s to the status register clears those bits. An event in the same cycle wins. `irq` is the OR of status AND NOT mask.
- R11: Register map by `reg_addr`: 0 control, 1 count (read only), 2 ceiling, 3 status, 4 mask. Any other address reads 0. After reset the values are: control 0, count 0, ceiling all ones, status 0, mask 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| index_in | input | 1 | Encoder index, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| count_o | output | CNT_W | Current position count |
| dir_up | output | 1 | Direction of the last valid step, 1 = up |
| irq | output | 1 | Unmasked interrupt request |

## Verification
Two pairs of functions can land on the same clock edge:
- **Index reset and step.** The bench raises the index in the same cycle as a phase step that also brings {A,B} into the gate pattern. It expects the count to be zero and not incremented.
- **Clear and event.** The bench times a write-one-to-clear to the status register so that it lands exactly two cycles after a phase change. That phase change causes a direction reversal and a wrap. The bench expects the old watchdog flag to vanish while the direction and wrap flags stay set.

A behavioural model in the bench predicts the count, direction, irq and read data on every clock, and any mismatch is reported against the requirement under test.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam int NUM_IRQ = 5;
  localparam int CTRL_W  = 5;

  // status bit positions
  localparam int IRQ_WDOG    = 0;
  localparam int IRQ_WRAP_DN = 1;
  localparam int IRQ_WRAP_UP = 2;
  localparam int IRQ_DIR     = 3;
  localparam int IRQ_PERR    = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_COUNT = 3'd1,
    A_CEIL  = 3'd2,
    A_STAT  = 3'd3,
    A_MASK  = 3'd4
  } reg_addr_e;

  // packed: last member is bit 0
  typedef struct packed {
    logic [1:0] gate;
    logic       idx_rst;
    logic       swap;
    logic       en;
  } ctrl_t;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_ERR  = 2'd2,
    STEP_DOWN = 2'd3
  } step_e;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/qenc_phase_decode.sv
module qenc_phase_decode
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_s,
  input  logic       b_s,
  input  logic       idx_s,
  input  logic       swap,
  input  logic [1:0] gate,
  output step_e      step,
  output logic       idx_hit
);
  logic a_p, b_p, idx_p;
  logic a_now, b_now, a_old, b_old;
  logic [1:0] pos_now, pos_old, delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_p   <= 1'b0;
      b_p   <= 1'b0;
      idx_p <= 1'b0;
    end else begin
      a_p   <= a_s;
      b_p   <= b_s;
      idx_p <= idx_s;
    end
  end

  always_comb begin
    a_now = swap ? b_s : a_s;
    b_now = swap ? a_s : b_s;
    a_old = swap ? b_p : a_p;
    b_old = swap ? a_p : b_p;
    // Gray position: 00->0, 10->1, 11->2, 01->3
    pos_now = {b_now, a_now ^ b_now};
    pos_old = {b_old, a_old ^ b_old};
    delta   = pos_now - pos_old;
    step    = step_e'(delta);
    idx_hit = idx_s && !idx_p && ({a_now, b_now} == gate);
  end
endmodule

// File: rtl/qenc_position.sv
module qenc_position
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int WDOG_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               idx_rst_en,
  input  step_e              step,
  input  logic               idx_hit,
  input  logic [CNT_W-1:0]   ceiling,
  output logic [CNT_W-1:0]   count,
  output logic               dir_up,
  output logic [NUM_IRQ-1:0] evt
);
  localparam int WD_W = $clog2(WDOG_CYCLES + 1);
  localparam logic [WD_W-1:0] WD_LIM = WD_W'(WDOG_CYCLES);

  logic [CNT_W-1:0] count_q, count_d;
  logic             dir_q, dir_d;
  logic [WD_W-1:0]  wd_q, wd_d;
  logic             step_ok, idx_act;

  always_comb begin
    count_d = count_q;
    dir_d   = dir_q;
    wd_d    = wd_q;
    evt     = '0;
    step_ok = (step == STEP_UP) || (step == STEP_DOWN);
    idx_act = idx_hit && idx_rst_en;
    if (en) begin
      if (step_ok) begin
        wd_d = '0;
      end else if (wd_q != WD_LIM) begin
        wd_d = wd_q + 1'b1;
        if (wd_q == WD_LIM - 1'b1) evt[IRQ_WDOG] = 1'b1;
      end
      if (step_ok) begin
        dir_d = (step == STEP_UP);
        if (dir_d != dir_q) evt[IRQ_DIR] = 1'b1;
      end
      if (step == STEP_ERR) evt[IRQ_PERR] = 1'b1;
      if (idx_act) begin
        count_d = '0;
        if (dir_q) evt[IRQ_WRAP_UP] = 1'b1;
        else       evt[IRQ_WRAP_DN] = 1'b1;
      end else if (step == STEP_UP) begin
        if (count_q >= ceiling) begin
          count_d = '0;
          evt[IRQ_WRAP_UP] = 1'b1;
        end else begin
          count_d = count_q + 1'b1;
        end
      end else if (step == STEP_DOWN) begin
        if (count_q == '0) begin
          count_d = ceiling;
          evt[IRQ_WRAP_DN] = 1'b1;
        end else begin
          count_d = count_q - 1'b1;
        end
      end
    end else begin
      wd_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      dir_q   <= 1'b1;
    end else if (en) begin
      count_q <= count_d;
      dir_q   <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_q <= '0;
    else        wd_q <= wd_d;
  end

  assign count  = count_q;
  assign dir_up = dir_q;

  // R7
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(count_q) && $stable(dir_q)));

  // R4
  phase_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step == STEP_ERR && !idx_act) |=> $stable(count_q));

  // R3
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step_ok && !idx_act) |=>
      (count_q == CNT_W'($past(count_q) + 1'b1)) ||
      (count_q == CNT_W'($past(count_q) - 1'b1)) ||
      (count_q == '0) || (count_q == $past(ceiling)));

  // R9
  wdog_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[IRQ_WDOG] |=> !evt[IRQ_WDOG]);
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int WDOG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_a,
  input  logic              phase_b,
  input  logic              index_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_up,
  output logic              irq
);
  logic rst_core_n;
  logic [2:0] in_s;
  step_e step;
  logic idx_hit;
  logic [NUM_IRQ-1:0] evt;

  ctrl_t              ctrl_q, ctrl_d;
  logic [CNT_W-1:0]   ceil_q, ceil_d;
  logic [NUM_IRQ-1:0] stat_q, stat_d, mask_q, mask_d, clr;
  logic wr_ctrl, wr_ceil, wr_stat, wr_mask;
  logic unused_wdata_bits;

  assign unused_wdata_bits = ^reg_wdata[DATA_W-1:CNT_W];

  qenc_sync #(.W(1), .STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n));

  qenc_sync #(.W(3), .STAGES(2)) i_in_sync (
    .clk(clk), .rst_n(rst_core_n),
    .d({index_in, phase_b, phase_a}), .q(in_s));

  qenc_phase_decode i_decode (
    .clk(clk), .rst_n(rst_core_n),
    .a_s(in_s[0]), .b_s(in_s[1]), .idx_s(in_s[2]),
    .swap(ctrl_q.swap), .gate(ctrl_q.gate),
    .step(step), .idx_hit(idx_hit));

  qenc_position #(.CNT_W(CNT_W), .WDOG_CYCLES(WDOG_CYCLES)) i_position (
    .clk(clk), .rst_n(rst_core_n),
    .en(ctrl_q.en), .idx_rst_en(ctrl_q.idx_rst),
    .step(step), .idx_hit(idx_hit), .ceiling(ceil_q),
    .count(count_o), .dir_up(dir_up), .evt(evt));

  always_comb begin
    wr_ctrl = reg_we && (reg_addr == A_CTRL);
    wr_ceil = reg_we && (reg_addr == A_CEIL);
    wr_stat = reg_we && (reg_addr == A_STAT);
    wr_mask = reg_we && (reg_addr == A_MASK);

    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      if (ctrl_q.en) ctrl_d.en = reg_wdata[0];
      else           ctrl_d    = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end
    ceil_d = (wr_ceil && !ctrl_q.en) ? reg_wdata[CNT_W-1:0] : ceil_q;
    clr    = wr_stat ? reg_wdata[NUM_IRQ-1:0] : '0;
    stat_d = (stat_q & ~clr) | evt;
    mask_d = wr_mask ? reg_wdata[NUM_IRQ-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctrl_q <= '0;
      ceil_q <= '1;
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_ceil) ceil_q <= ceil_d;
      stat_q <= stat_d;
      if (wr_mask) mask_q <= mask_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DATA_W'(ctrl_q);
      A_COUNT: reg_rdata = DATA_W'(count_o);
      A_CEIL:  reg_rdata = DATA_W'(ceil_q);
      A_STAT:  reg_rdata = DATA_W'(stat_q);
      A_MASK:  reg_rdata = DATA_W'(mask_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(stat_q & ~mask_q);

  // R8
  ceil_lock_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ctrl_q.en |=> $stable(ceil_q));

  // R8
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ctrl_q.en |=> (ctrl_q[CTRL_W-1:1] == $past(ctrl_q[CTRL_W-1:1])));

  // R10
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(reg_we && reg_addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: tb/test_qenc_counter.sv
module test_qenc_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        phase_a, phase_b, index_in;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [15:0] count_o;
  logic        dir_up, irq;

  qenc_counter #(.CNT_W(16), .WDOG_CYCLES(64)) i_qenc_counter (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .index_in(index_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_o(count_o),
    .dir_up(dir_up), .irq(irq));

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  string cur_req = "R11";
  bit cmp_on = 0;
  int bpos = 0;

  // behavioural model
  int       m_count, m_ceil, m_idle;
  bit       m_dir;
  bit [4:0] m_ctrl, m_stat, m_mask, m_set, m_clr;
  bit [2:0] q1, q2, q3;
  bit       m_en, a2, b2, a3, b3, ihit, ndir;
  int       pn, pp, dlt;
  localparam int WD = 64;

  function automatic int pos_of(bit a, bit b);
    case ({a, b})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] ad);
    case (ad)
      3'd0:    return {27'd0, m_ctrl};
      3'd1:    return m_count;
      3'd2:    return m_ceil;
      3'd3:    return {27'd0, m_stat};
      3'd4:    return {27'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_count = 0; m_ceil = 16'hFFFF; m_idle = 0; m_dir = 1;
      m_ctrl = 0; m_stat = 0; m_mask = 5'h1F; q1 = 0; q2 = 0; q3 = 0;
    end else begin
      m_en = m_ctrl[0];
      a2 = m_ctrl[1] ? q2[1] : q2[0];
      b2 = m_ctrl[1] ? q2[0] : q2[1];
      a3 = m_ctrl[1] ? q3[1] : q3[0];
      b3 = m_ctrl[1] ? q3[0] : q3[1];
      pn = pos_of(a2, b2);
      pp = pos_of(a3, b3);
      dlt = (pn - pp + 4) % 4;
      ihit = q2[2] && !q3[2] && ({a2, b2} == m_ctrl[4:3]);
      m_set = 0;
      if (m_en) begin
        if (dlt == 1 || dlt == 3) m_idle = 0;
        else if (m_idle < WD) begin
          m_idle++;
          if (m_idle == WD) m_set[0] = 1;
        end
        ndir = m_dir;
        if (dlt == 1) ndir = 1;
        if (dlt == 3) ndir = 0;
        if ((dlt == 1 || dlt == 3) && ndir != m_dir) m_set[3] = 1;
        if (dlt == 2) m_set[4] = 1;
        if (ihit && m_ctrl[2]) begin
          m_count = 0;
          if (m_dir) m_set[2] = 1; else m_set[1] = 1;
        end else if (dlt == 1) begin
          if (m_count >= m_ceil) begin m_count = 0; m_set[2] = 1; end
          else m_count++;
        end else if (dlt == 3) begin
          if (m_count == 0) begin m_count = m_ceil; m_set[1] = 1; end
          else m_count--;
        end
        m_dir = ndir;
      end else m_idle = 0;
      m_clr = (reg_we && reg_addr == 3'd3) ? reg_wdata[4:0] : 5'd0;
      m_stat = (m_stat & ~m_clr) | m_set;
      if (reg_we) begin
        case (reg_addr)
          3'd0: if (m_en) m_ctrl[0] = reg_wdata[0]; else m_ctrl = reg_wdata[4:0];
          3'd2: if (!m_en) m_ceil = reg_wdata[15:0];
          3'd4: m_mask = reg_wdata[4:0];
          default: ;
        endcase
      end
      q3 = q2; q2 = q1; q1 = {index_in, phase_b, phase_a};
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      check(cur_req, "count", {16'd0, count_o}, m_count);
      check(cur_req, "dir", {31'd0, dir_up}, {31'd0, m_dir});
      check(cur_req, "irq", {31'd0, irq}, {31'd0, |(m_stat & ~m_mask)});
      check(cur_req, "rdata", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_pos();
    case (bpos & 3)
      0: begin phase_a = 0; phase_b = 0; end
      1: begin phase_a = 1; phase_b = 0; end
      2: begin phase_a = 1; phase_b = 1; end
      default: begin phase_a = 0; phase_b = 1; end
    endcase
  endtask

  task automatic steps(int n, bit up);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bpos = up ? bpos + 1 : bpos + 3;
      drive_pos();
      tick(1);
    end
    tick(4);
  endtask

  task automatic wr(logic [2:0] ad, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = ad; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_addr = 3'd1;
  endtask

  task automatic rd_expect(string req, logic [2:0] ad, logic [31:0] exp);
    @(negedge clk);
    reg_addr = ad;
    #1;
    check(req, "read", reg_rdata, exp);
  endtask

  task automatic idx_pulse();
    @(negedge clk); index_in = 1;
    tick(2);
    index_in = 0;
    tick(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL timeout actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; phase_a = 0; phase_b = 0; index_in = 0;
    reg_we = 0; reg_addr = 3'd1; reg_wdata = 0;
    tick(4);
    rst_n = 1;
    tick(4);
    cmp_on = 1;

    cur_req = "R11";
    check("R11", "reset count", {16'd0, count_o}, 0);
    check("R5", "reset dir", {31'd0, dir_up}, 1);
    rd_expect("R11", 3'd4, 32'h1F);
    rd_expect("R11", 3'd2, 32'hFFFF);
    rd_expect("R11", 3'd0, 32'h0);
    rd_expect("R11", 3'd6, 32'h0);

    wr(3'd2, 32'd5);
    wr(3'd4, 32'd0);
    wr(3'd0, 32'h1D);  // enable, index reset, gate {A,B}=11
    cur_req = "R1";
    steps(3, 1);
    check("R1", "count up", {16'd0, count_o}, 3);
    cur_req = "R3";
    steps(4, 1);
    check("R3", "wrap up", {16'd0, count_o}, 1);
    rd_expect("R3", 3'd3, 32'h04);
    cur_req = "R5";
    steps(3, 0);
    check("R3", "wrap down", {16'd0, count_o}, 4);
    check("R5", "dir down", {31'd0, dir_up}, 0);
    rd_expect("R5", 3'd3, 32'h0E);

    cur_req = "R10";
    check("R10", "irq pending", {31'd0, irq}, 1);
    wr(3'd3, 32'h1F);
    rd_expect("R10", 3'd3, 32'h0);

    cur_req = "R8";
    wr(3'd2, 32'd9);
    rd_expect("R8", 3'd2, 32'd5);
    wr(3'd0, 32'h02);
    rd_expect("R8", 3'd0, 32'h1C);
    wr(3'd0, 32'h1D);

    cur_req = "R4";
    @(negedge clk); bpos = bpos + 2; drive_pos();
    tick(5);
    check("R4", "err hold", {16'd0, count_o}, 4);
    rd_expect("R4", 3'd3, 32'h10);

    cur_req = "R6";
    idx_pulse();
    check("R6", "index reset", {16'd0, count_o}, 0);
    steps(1, 1);
    idx_pulse();
    check("R6", "gate mismatch", {16'd0, count_o}, 1);
    steps(2, 1);
    @(negedge clk); bpos = bpos + 1; drive_pos(); index_in = 1;
    tick(2); index_in = 0; tick(4);
    check("R6", "index beats step", {16'd0, count_o}, 0);
    steps(2, 1);
    wr(3'd0, 32'h00);
    wr(3'd0, 32'h01);  // index reset off, gate 00
    idx_pulse();
    check("R6", "index ignored", {16'd0, count_o}, 2);

    cur_req = "R2";
    wr(3'd0, 32'h00);
    wr(3'd0, 32'h03);
    steps(3, 1);
    check("R2", "swap counts down", {16'd0, count_o}, 5);

    cur_req = "R7";
    wr(3'd0, 32'h00);
    steps(4, 1);
    check("R7", "disabled hold", {16'd0, count_o}, 5);

    cur_req = "R9";
    wr(3'd3, 32'h1F);
    wr(3'd0, 32'h01);
    tick(70);
    rd_expect("R9", 3'd3, 32'h01);

    cur_req = "R10";
    @(negedge clk); bpos = bpos + 1; drive_pos();
    tick(1);
    wr(3'd3, 32'h1F);
    tick(3);
    rd_expect("R10", 3'd3, 32'h0C);
    wr(3'd4, 32'h1F);
    check("R10", "masked irq", {31'd0, irq}, 0);
    tick(3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule